// File: doc/BRIEF.md
# Serial Frame Receiver with Parity Check

This block recovers asynchronous serial frames from a single receive line. A frame is a low start bit, eight data bits sent least significant bit first, one parity bit and a high stop bit. The clock rate, the line rate and the parity sense (odd or even) are set by parameters. One bit lasts `CLK_HZ / BAUD` clocks. The receiver samples each bit once, near the middle of the bit.

The receive line first passes through a two-flop synchroniser. After reset the receiver stays disarmed until it sees the line high, so a line that is held low does not start a false frame. Once armed, a falling edge in idle starts a frame. The receiver then raises a busy flag, clears its error flag and times the samples for each bit. When the stop bit has been sampled, it presents the byte and pulses a done strobe for one clock. In that same clock it gives an error verdict that covers the start bit, the parity and the stop bit. The verdict stays on the error output until the next start edge.

Top module: `serial_rx_par`

## Requirements
- R1: After reset the receiver ignores the line until the line is first seen high. A line held low out of reset never raises `rx_busy` or `rx_done`.
- R2: `rx_busy` is high from the clock after a start edge is detected until the clock in which `rx_done` pulses. In that clock `rx_busy` is low, and it is low at all times between frames.
- R3: `rx_done` is high for exactly one clock per received frame, and `rx_byte` holds the new byte in that clock. `rx_byte` changes at no other time.
- R4: The data bits follow the start bit with the least significant bit first. Bit k of the frame's data field lands in `rx_byte[k]`.
- R5: With `ODD_PARITY`=1, the eight data bits plus the parity bit must contain an odd number of ones. With `ODD_PARITY`=0, they must contain an even number. A mismatch sets `rx_err` at the end of the frame.
- R6: If the line is high at the start-bit sample point, for example because the line fell for only a short glitch, `rx_err` is set when the frame completes.
- R7: If the line is low at the stop-bit sample point, `rx_err` is set when the frame completes.
- R8: `rx_err` is cleared in the clock after a start edge is detected. Otherwise it changes only together with `rx_done`, and it holds its value between frames.
- R9: A frame with any error still produces the single `rx_done` pulse and updates `rx_byte`.
- R10: While `rst` is high, `rx_byte` is zero and `rx_busy`, `rx_done` and `rx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| rx_byte | output | 8 | Last received data byte |
| rx_busy | output | 1 | High while a frame is being received |
| rx_done | output | 1 | One-clock pulse when a frame completes |
| rx_err | output | 1 | Error verdict of the last frame (start, parity or stop fault) |

## Verification
The error verdict and the done strobe come out in the same clock. In that same clock the busy flag drops. The bench captures the byte and the error flag only in the clock where the strobe is seen. It compares them with values computed from the driven bits. It also counts strobes, so that a frame which produces two strobes, or none, is reported. The sweep runs all 256 bytes with both parity-bit values into an odd-parity and an even-parity receiver on the same line. Every frame must therefore bring a strobe with a clean verdict in one receiver and a parity error in the other. Frames with a glitched start bit or a low stop bit then test that the strobe still fires with the error set. They also test that the flag is held until the next start edge clears it partway through a frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_ARM    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_START  = 3'd2,
    ST_DATA   = 3'd3,
    ST_PARITY = 3'd4,
    ST_STOP   = 3'd5
  } rx_state_e;

  // clocks spent on one bit of the line
  function automatic int clocks_per_bit(input longint clk_hz, input longint baud);
    return int'(clk_hz / baud);
  endfunction

  // delay from the start edge to the start-bit sample point
  function automatic int half_bit(input int bit_clks);
    return (bit_clks / 2 < 1) ? 1 : bit_clks / 2;
  endfunction

  // 1 when data plus parity bit disagree with the chosen sense
  function automatic logic parity_fault(input logic [BYTE_W-1:0] data,
                                        input logic pbit,
                                        input logic odd);
    return ((^data) ^ pbit) != odd;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              line_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= rx_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_d <= 1'b0;
    else     line_d <= chain[STAGES-1];
  end

  assign line = chain[STAGES-1];
  assign fall = line_d & ~line;
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int BIT_CLKS  = 8,
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (restart)   cnt <= CNT_W'(HALF_CLKS - 1);
    else if (tick)      cnt <= CNT_W'(BIT_CLKS - 1);
    else if (run)       cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import serial_rx_pkg::*;
#(
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              fall,
  input  logic              tick,
  output logic              timer_restart,
  output logic              timer_run,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_done,
  output logic              rx_err,
  output logic              rx_busy,
  output logic              line_armed,
  output logic              start_seen,
  output logic              frame_end
);
  localparam int IDX_W = $clog2(BYTE_W);

  rx_state_e         state;
  logic [IDX_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic              start_bad;
  logic              par_bit;

  assign rx_busy       = (state == ST_START) || (state == ST_DATA) ||
                         (state == ST_PARITY) || (state == ST_STOP);
  assign line_armed    = (state != ST_ARM);
  assign start_seen    = (state == ST_IDLE) && fall;
  assign frame_end     = (state == ST_STOP) && tick;
  assign timer_restart = start_seen;
  assign timer_run     = rx_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ARM;
      bit_idx   <= '0;
      shreg     <= '0;
      start_bad <= 1'b0;
      par_bit   <= 1'b0;
      rx_byte   <= '0;
      rx_done   <= 1'b0;
      rx_err    <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      unique case (state)
        ST_ARM: begin
          if (line) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (fall) begin
            state  <= ST_START;
            rx_err <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            start_bad <= line;
            bit_idx   <= '0;
            state     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick) begin
            shreg <= {line, shreg[BYTE_W-1:1]};
            if (bit_idx == IDX_W'(BYTE_W - 1)) state <= ST_PARITY;
            else                               bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_PARITY: begin
          if (tick) begin
            par_bit <= line;
            state   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (tick) begin
            rx_byte <= shreg;
            rx_done <= 1'b1;
            rx_err  <= start_bad | parity_fault(shreg, par_bit, ODD_PARITY) | ~line;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_ARM;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_par.sv
module serial_rx_par
  import serial_rx_pkg::*;
#(
  parameter longint CLK_HZ      = 100_000_000,
  parameter longint BAUD        = 19_200,
  parameter bit     ODD_PARITY  = 1'b1,
  parameter int     SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_busy,
  output logic              rx_done,
  output logic              rx_err
);
  localparam int BIT_CLKS  = clocks_per_bit(CLK_HZ, BAUD);
  localparam int HALF_CLKS = half_bit(BIT_CLKS);

  logic line, fall, tick;
  logic timer_restart, timer_run;
  logic line_armed, start_seen, frame_end;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .rx_in(rx_in),
    .line (line),
    .fall (fall)
  );

  rx_bit_timer #(.BIT_CLKS(BIT_CLKS), .HALF_CLKS(HALF_CLKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(timer_restart),
    .run    (timer_run),
    .tick   (tick)
  );

  rx_frame_ctrl #(.ODD_PARITY(ODD_PARITY)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .line         (line),
    .fall         (fall),
    .tick         (tick),
    .timer_restart(timer_restart),
    .timer_run    (timer_run),
    .rx_byte      (rx_byte),
    .rx_done      (rx_done),
    .rx_err       (rx_err),
    .rx_busy      (rx_busy),
    .line_armed   (line_armed),
    .start_seen   (start_seen),
    .frame_end    (frame_end)
  );
endmodule

// File: rtl/serial_rx_par_chk.sv
module serial_rx_par_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rx_byte,
  input logic       rx_busy,
  input logic       rx_done,
  input logic       rx_err,
  input logic       line_armed,
  input logic       start_seen,
  input logic       frame_end
);
  // R1
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !line_armed |-> (!rx_busy && !rx_done));

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> rx_busy);

  // R2
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> !rx_busy);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(rx_byte));

  // R9
  end_gives_done_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> rx_done);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> !rx_err);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_seen && !frame_end) |=> $stable(rx_err));
endmodule

bind serial_rx_par serial_rx_par_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_byte   (rx_byte),
  .rx_busy   (rx_busy),
  .rx_done   (rx_done),
  .rx_err    (rx_err),
  .line_armed(line_armed),
  .start_seen(start_seen),
  .frame_end (frame_end)
);

// File: tb/serial_rx_par_bench.sv
module serial_rx_par_bench;
  localparam longint CLK_HZ  = 8_000_000;
  localparam longint BAUD    = 1_000_000;
  localparam int     BIT     = int'(CLK_HZ / BAUD);
  localparam int     WD_CYC  = 150_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b0;
  logic [7:0] byte_o, byte_e;
  logic       busy_o, busy_e, done_o, done_e, err_o, err_e;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int   cnt_o = 0, cnt_e = 0, wide = 0;
  logic [7:0] cap_byte_o, cap_byte_e;
  logic       cap_err_o, cap_err_e;
  logic       prev_o = 0, prev_e = 0;

  always #4 clk = ~clk;

  serial_rx_par #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ODD_PARITY(1'b1)) u_serial_rx_par (
    .clk(clk), .rst(rst), .rx_in(rx_line),
    .rx_byte(byte_o), .rx_busy(busy_o), .rx_done(done_o), .rx_err(err_o)
  );

  serial_rx_par #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ODD_PARITY(1'b0)) u_serial_rx_par_even (
    .clk(clk), .rst(rst), .rx_in(rx_line),
    .rx_byte(byte_e), .rx_busy(busy_e), .rx_done(done_e), .rx_err(err_e)
  );

  // strobe monitor, away from the active edge
  always @(negedge clk) begin
    if (done_o) begin cnt_o++; cap_byte_o = byte_o; cap_err_o = err_o; end
    if (done_e) begin cnt_e++; cap_byte_e = byte_e; cap_err_e = err_e; end
    if ((done_o && prev_o) || (done_e && prev_e)) wide++;
    prev_o = done_o;
    prev_e = done_e;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_line = v;
    end
  endtask

  // drive one frame; glitch_start makes the start bit only two clocks long
  task automatic send(input logic [7:0] b, input logic pbit, input bit glitch_start,
                      input logic stop_v);
    if (glitch_start) begin
      hold(1'b0, 2);
      hold(1'b1, BIT - 2);
    end else begin
      hold(1'b0, BIT);
    end
    for (int k = 0; k < 8; k++) hold(b[k], BIT);
    hold(pbit, BIT / 2);
    // R2 busy mid-frame, R8 verdict cleared once the start edge was taken
    chk("R2 busy mid-frame odd", busy_o, 1);
    chk("R2 busy mid-frame even", busy_e, 1);
    chk("R8 err cleared at start odd", err_o, 0);
    chk("R8 err cleared at start even", err_e, 0);
    hold(pbit, BIT - BIT / 2);
    hold(stop_v, BIT);
    hold(1'b1, 4);
  endtask

  task automatic frame(input logic [7:0] b, input logic pbit, input bit glitch_start,
                       input logic stop_v, input logic [7:0] exp_b,
                       input logic exp_eo, input logic exp_ee, input string tag);
    int c0o, c0e;
    c0o = cnt_o;
    c0e = cnt_e;
    send(b, pbit, glitch_start, stop_v);
    @(negedge clk);
    chk({tag, " R3/R9 one strobe odd"}, cnt_o - c0o, 1);
    chk({tag, " R3/R9 one strobe even"}, cnt_e - c0e, 1);
    chk({tag, " R4 byte odd"}, cap_byte_o, exp_b);
    chk({tag, " R4 byte even"}, cap_byte_e, exp_b);
    chk({tag, " R5 verdict odd"}, cap_err_o, exp_eo);
    chk({tag, " R5 verdict even"}, cap_err_e, exp_ee);
    chk({tag, " R2 idle busy low"}, {busy_o, busy_e}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 outputs during reset
    chk("R10 reset byte", {byte_o, byte_e}, 0);
    chk("R10 reset flags", {busy_o, done_o, err_o, busy_e, done_e, err_e}, 0);
    @(negedge clk);
    rst = 1'b0;
    // R1 line held low out of reset is not a start bit
    hold(1'b0, 40);
    chk("R1 low line no busy", {busy_o, busy_e}, 0);
    chk("R1 low line no strobe", cnt_o + cnt_e, 0);
    hold(1'b1, 10);
    chk("R1 armed idle not busy", {busy_o, busy_e}, 0);

    // R4 R5: exhaustive bytes with both parity-bit values
    for (int b = 0; b < 256; b++) begin
      for (int p = 0; p < 2; p++) begin
        logic ones;
        ones = (^b[7:0]) ^ p[0];
        frame(b[7:0], p[0], 0, 1'b1, b[7:0], ones != 1'b1, ones != 1'b0, "sweep");
      end
    end

    // R7 low stop bit, good parity for the odd receiver
    frame(8'hA5, ~(^8'hA5), 0, 1'b0, 8'hA5, 1'b1, 1'b1, "R7 stop");
    // R8 verdict held between frames
    hold(1'b1, 30);
    chk("R8 err held odd", err_o, 1);
    chk("R8 err held even", err_e, 1);

    // R6 glitched start: line stays high, receiver sees all ones
    frame(8'hFF, 1'b1, 1, 1'b1, 8'hFF, 1'b1, 1'b1, "R6 start");

    // clean frame after errors; R8 clear checked inside send
    frame(8'h3C, ~(^8'h3C), 0, 1'b1, 8'h3C, 1'b0, 1'b1, "R9 recover");

    chk("R3 strobe width one clock", wide, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule